// File: doc/BRIEF.md
# All-Pairs Shortest Path and Path-Length Statistics Engine

This block takes a square weighted connectivity matrix of N nodes, where a weight near full scale means a strong link and a weight of zero means no link. It turns every weight into a distance and finds the shortest distance between every ordered pair of nodes. From those distances it derives three kinds of result. The first is the characteristic path length, which is the mean shortest distance over all ordered pairs of distinct nodes. The second is each node's eccentricity. The third is the network radius and diameter.

A pulse on `start` makes the block read the whole matrix, one entry per cycle, through a read port with a latency of one cycle. The block keeps the converted distances in a local store. It then runs a greedy shortest-path search from each source node in turn. Each step of the search picks the nearest node not yet visited and relaxes every tentative distance through it. When the last source is finished, the results are loaded into output registers and `done` pulses.

Top module: `path_stats`

## Requirements
- R1: A weight w > 0 becomes the distance (2^WW − 1 − w) + OFFS, clipped to 2^DW − 1. A weight of 0 becomes the largest distance, 2^DW − 1.
- R2: The shortest distance from i to j (i ≠ j) is the least sum of edge distances over all paths from i to j. Every sum saturates at 2^DW − 1.
- R3: `ecc` holds node i's eccentricity in bits [i·DW +: DW]. A node's eccentricity is the largest shortest distance from that node to any other node.
- R4: `radius` is the smallest eccentricity and `diameter` is the largest.
- R5: Let S be the sum of all N²−N shortest distances. Then `cpl` equals (S · RCP) >> (RB − FW), where RCP = ceil(2^RB / (N²−N)). This is a value with FW fraction bits.
- R6: After `start`, the block drives every matrix address exactly once, in row-major order: in the c-th cycle after the start edge, `rd_row` = c / N and `rd_col` = c mod N. `rd_data` must return the addressed weight one cycle later.
- R7: `done` is high for exactly one cycle. It rises 2N²+N+2 clock edges after the edge that samples `start`. All results hold their values until the next `done`.
- R8: A `start` that arrives while a computation is running has no effect on that computation's timing or results.
- R9: After reset, `done`, `cpl`, `ecc`, `radius` and `diameter` are all zero.
- R10: The weights on the diagonal do not affect any result, because a node's distance to itself is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a computation (taken only when idle) |
| rd_row | output | IW | Matrix read row address |
| rd_col | output | IW | Matrix read column address |
| rd_data | input | WW | Weight at the address driven one cycle earlier |
| cpl | output | DW+FW+1 | Characteristic path length, FW fraction bits |
| ecc | output | N·DW | Eccentricities, node i at bits [i·DW +: DW] |
| radius | output | DW | Minimum eccentricity |
| diameter | output | DW | Maximum eccentricity |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench computes its expected shortest distances with a saturating all-pairs relaxation, which is a different method from the one the block uses. Against that reference it applies several matrix patterns:

- A fully connected uniform matrix gives every distance as one hop, which exposes errors in the weight mapping alone.
- Symmetric pseudo-random matrices make the greedy node choice and the relaxation matter.
- A chain with no direct long edges forces multi-hop paths and gives the centre node a smaller eccentricity than the ends.
- An isolated node drives the sums into saturation.
- A random matrix is repeated with a non-zero diagonal, to show that the diagonal is ignored.
- A run with extra start pulses during loading and searching shows that they are ignored.

// File: rtl/path_pkg.sv
package path_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_LDLAST, S_INIT, S_STEP, S_FIN, S_DONE
  } path_state_t;
endpackage

// File: rtl/path_dist_map.sv
module path_dist_map #(
  parameter int WW   = 8,
  parameter int DW   = 10,
  parameter int OFFS = 1
) (
  input  logic [WW-1:0] w,
  output logic [DW-1:0] d
);
  localparam int TW = (DW > WW ? DW : WW) + 2;
  localparam logic [TW-1:0] FULL = TW'((1 << WW) - 1);
  localparam logic [TW-1:0] DMAXT = TW'((1 << DW) - 1);

  logic [TW-1:0] t;

  always_comb begin
    t = (FULL - TW'(w)) + TW'(OFFS);
    if (w == '0)        d = '1;
    else if (t > DMAXT) d = '1;
    else                d = t[DW-1:0];
  end
endmodule

// File: rtl/path_min_pick.sv
module path_min_pick #(
  parameter int N  = 5,
  parameter int DW = 10,
  parameter int IW = 3
) (
  input  logic [N*DW-1:0] vals,
  input  logic [N-1:0]    excl,
  output logic [IW-1:0]   idx
);
  logic [DW-1:0] bv;
  logic          found;

  always_comb begin
    idx   = '0;
    bv    = '1;
    found = 1'b0;
    for (int j = 0; j < N; j++) begin
      if (!excl[j] && (!found || vals[j*DW +: DW] < bv)) begin
        found = 1'b1;
        bv    = vals[j*DW +: DW];
        idx   = IW'(j);
      end
    end
  end
endmodule

// File: rtl/path_stats.sv
module path_stats
  import path_pkg::*;
#(
  parameter int N    = 5,
  parameter int WW   = 8,
  parameter int DW   = 10,
  parameter int OFFS = 1,
  parameter int FW   = 8,
  parameter int RB   = 24,
  localparam int IW  = (N > 1) ? $clog2(N) : 1,
  localparam int CW  = DW + FW + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  output logic [IW-1:0]   rd_row,
  output logic [IW-1:0]   rd_col,
  input  logic [WW-1:0]   rd_data,
  output logic [CW-1:0]   cpl,
  output logic [N*DW-1:0] ecc,
  output logic [DW-1:0]   radius,
  output logic [DW-1:0]   diameter,
  output logic            done
);
  localparam int SW   = DW + $clog2(N * N);
  localparam int RDEN = N * N - N;
  localparam longint RCPL = ((64'd1 << RB) + longint'(RDEN) - 1) / longint'(RDEN);
  localparam logic [RB:0] RCP = RCPL[RB:0];
  localparam int PW   = SW + RB + 1;
  localparam logic [DW-1:0] DMAX = '1;

  path_state_t st;
  logic [IW-1:0] lr, lc, ld_r, ld_c, src, stp, kpick;
  logic          ld_v;
  logic [DW-1:0] dmem [N][N];
  logic [DW-1:0] tent [N];
  logic [DW-1:0] newt [N];
  logic [DW-1:0] ecc_w [N];
  logic [N*DW-1:0] tent_flat;
  logic [N-1:0]  vis;
  logic [SW-1:0] sum, fsum;
  logic [DW-1:0] fmax, rad_w, dia_w, mapped;
  logic [PW-1:0] prod;

  assign rd_row = lr;
  assign rd_col = lc;

  path_dist_map #(.WW(WW), .DW(DW), .OFFS(OFFS)) u_map (.w(rd_data), .d(mapped));

  // distance store: one write per cycle, no reset
  always_ff @(posedge clk)
    if (ld_v) dmem[ld_r][ld_c] <= mapped;

  for (genvar g = 0; g < N; g++) begin : g_flat
    assign tent_flat[g*DW +: DW] = tent[g];
  end

  path_min_pick #(.N(N), .DW(DW), .IW(IW)) u_pick (
    .vals(tent_flat), .excl(vis), .idx(kpick));

  // relaxation through the picked node, all targets in parallel
  always_comb begin
    for (int j = 0; j < N; j++) begin
      logic [DW:0] s;
      s = {1'b0, tent[kpick]} + {1'b0, dmem[kpick][j]};
      if (s[DW])            newt[j] = (DMAX < tent[j]) ? DMAX : tent[j];
      else if (s[DW-1:0] < tent[j]) newt[j] = s[DW-1:0];
      else                  newt[j] = tent[j];
    end
  end

  // per-source row reduction: max and sum over j != src
  always_comb begin
    fmax = '0;
    fsum = '0;
    for (int j = 0; j < N; j++) begin
      if (IW'(j) != src) begin
        fsum = fsum + SW'(tent[j]);
        if (tent[j] > fmax) fmax = tent[j];
      end
    end
  end

  assign prod = PW'(sum) * PW'(RCP);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      lr <= '0; lc <= '0; ld_r <= '0; ld_c <= '0; ld_v <= 1'b0;
      src <= '0; stp <= '0; vis <= '0; sum <= '0;
      rad_w <= '0; dia_w <= '0;
      cpl <= '0; ecc <= '0; radius <= '0; diameter <= '0; done <= 1'b0;
      for (int j = 0; j < N; j++) begin
        tent[j]  <= '0;
        ecc_w[j] <= '0;
      end
    end else begin
      done <= 1'b0;
      ld_v <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          st <= S_LOAD; lr <= '0; lc <= '0;
        end
        S_LOAD: begin
          ld_v <= 1'b1; ld_r <= lr; ld_c <= lc;
          if (lc == IW'(N-1)) begin
            lc <= '0;
            if (lr == IW'(N-1)) begin
              lr <= '0; st <= S_LDLAST;
            end else lr <= lr + 1'b1;
          end else lc <= lc + 1'b1;
        end
        S_LDLAST: begin
          st <= S_INIT; src <= '0; sum <= '0; rad_w <= DMAX; dia_w <= '0;
        end
        S_INIT: begin
          for (int j = 0; j < N; j++)
            tent[j] <= (IW'(j) == src) ? '0 : dmem[src][j];
          vis <= '0;
          vis[src] <= 1'b1;
          stp <= '0;
          st <= S_STEP;
        end
        S_STEP: begin
          for (int j = 0; j < N; j++) tent[j] <= newt[j];
          vis[kpick] <= 1'b1;
          if (stp == IW'(N-2)) st <= S_FIN;
          else stp <= stp + 1'b1;
        end
        S_FIN: begin
          ecc_w[src] <= fmax;
          sum <= sum + fsum;
          if (fmax < rad_w) rad_w <= fmax;
          if (fmax > dia_w) dia_w <= fmax;
          if (src == IW'(N-1)) st <= S_DONE;
          else begin
            src <= src + 1'b1; st <= S_INIT;
          end
        end
        S_DONE: begin
          cpl <= CW'(prod >> (RB - FW));
          for (int j = 0; j < N; j++) ecc[j*DW +: DW] <= ecc_w[j];
          radius <= rad_w;
          diameter <= dia_w;
          done <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  initial begin
    assert (N >= 2 && RB >= FW) else $error("path_stats: bad parameters");
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_rd_range_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_row < IW'(N)) && (rd_col < IW'(N)));

  p_pick_unvisited_r2: assert property (@(posedge clk) disable iff (rst)
    (st == S_STEP) |-> !vis[kpick]);

  p_self_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (st == S_STEP) |-> (tent[src] == '0));

  p_rad_le_dia_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> (radius <= diameter));

  for (genvar g = 0; g < N; g++) begin : g_chk
    p_tent_nonincr_r2: assert property (@(posedge clk) disable iff (rst)
      (st == S_STEP) |=> (tent[g] <= $past(tent[g])));
    p_ecc_bounds_r3: assert property (@(posedge clk) disable iff (rst)
      done |-> (ecc[g*DW +: DW] >= radius) && (ecc[g*DW +: DW] <= diameter));
  end
endmodule

// File: tb/path_stats_tb.sv
module path_stats_tb;
  localparam int CLK_NS = 10;
  localparam int N = 5, WW = 8, DW = 10, OFFS = 1, FW = 8, RB = 24;
  localparam int IW = $clog2(N);
  localparam int CW = DW + FW + 1;
  localparam int DMAX = (1 << DW) - 1;
  localparam int LAT = 2 * N * N + N + 2;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [IW-1:0] rd_row, rd_col;
  logic [WW-1:0] rd_data;
  logic [CW-1:0] cpl;
  logic [N*DW-1:0] ecc;
  logic [DW-1:0] radius, diameter;
  logic done;

  logic [WW-1:0] W [N][N];
  int exp_ecc [N];
  int exp_rad, exp_dia;
  longint exp_cpl;
  int nchk = 0, nfail = 0;
  int unsigned seed;

  path_stats #(.N(N), .WW(WW), .DW(DW), .OFFS(OFFS), .FW(FW), .RB(RB)) u_dut (
    .clk(clk), .rst(rst), .start(start), .rd_row(rd_row), .rd_col(rd_col),
    .rd_data(rd_data), .cpl(cpl), .ecc(ecc), .radius(radius),
    .diameter(diameter), .done(done));

  always #(CLK_NS/2) clk = ~clk;

  // external matrix memory, one-cycle read latency
  always_ff @(posedge clk) rd_data <= W[rd_row][rd_col];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dmap(input int w);
    int t;
    if (w == 0) return DMAX;
    t = ((1 << WW) - 1 - w) + OFFS;
    return (t > DMAX) ? DMAX : t;
  endfunction

  // saturating all-pairs relaxation reference (R1, R2, R3, R4, R5)
  task automatic compute_ref();
    int d [N][N];
    longint s, rcp;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        d[i][j] = (i == j) ? 0 : dmap(int'(W[i][j]));
    for (int k = 0; k < N; k++)
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) begin
          int t;
          t = d[i][k] + d[k][j];
          if (t > DMAX) t = DMAX;
          if (t < d[i][j]) d[i][j] = t;
        end
    s = 0; exp_rad = DMAX; exp_dia = 0;
    for (int i = 0; i < N; i++) begin
      exp_ecc[i] = 0;
      for (int j = 0; j < N; j++)
        if (i != j) begin
          s += d[i][j];
          if (d[i][j] > exp_ecc[i]) exp_ecc[i] = d[i][j];
        end
      if (exp_ecc[i] < exp_rad) exp_rad = exp_ecc[i];
      if (exp_ecc[i] > exp_dia) exp_dia = exp_ecc[i];
    end
    rcp = ((64'd1 << RB) + N*N - N - 1) / (N*N - N);
    exp_cpl = (s * rcp) >> (RB - FW);
  endtask

  task automatic run_check(input string tag, input bit poke);
    int cyc;
    logic [CW-1:0] held;
    compute_ref();
    @(negedge clk) start = 1'b1;
    @(posedge clk);
    @(negedge clk) start = 1'b0;
    cyc = 0;
    while (!done && cyc < 1000) begin
      if (cyc < N * N) begin  // R6 address order
        check(rd_row == IW'(cyc / N) && rd_col == IW'(cyc % N),
              {"R6 addr ", tag}, longint'(rd_row) * N + rd_col, cyc);
      end
      start = poke && (cyc == 10 || cyc == 40);  // R8 extra starts
      @(posedge clk); cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    check(cyc == LAT, poke ? {"R8 latency ", tag} : {"R7 latency ", tag}, cyc, LAT);
    for (int i = 0; i < N; i++)
      check(ecc[i*DW +: DW] == DW'(exp_ecc[i]), {"R3 ecc ", tag},
            ecc[i*DW +: DW], exp_ecc[i]);
    check(radius == DW'(exp_rad), {"R4 radius ", tag}, radius, exp_rad);
    check(diameter == DW'(exp_dia), {"R4 diameter ", tag}, diameter, exp_dia);
    check(cpl == CW'(exp_cpl), {"R5 cpl ", tag}, cpl, exp_cpl);
    held = cpl;
    @(negedge clk);
    check(!done, {"R7 pulse ", tag}, done, 0);
    repeat (3) @(negedge clk);
    check(cpl == held && radius == DW'(exp_rad), {"R7 hold ", tag}, cpl, held);
  endtask

  function automatic int unsigned lcg();
    seed = seed * 32'd1103515245 + 32'd12345;
    return (seed >> 16) & 32'hFF;
  endfunction

  task automatic fill_random(input int unsigned sd, input int diag);
    seed = sd;
    for (int i = 0; i < N; i++) begin
      W[i][i] = WW'(diag);
      for (int j = i + 1; j < N; j++) begin
        W[i][j] = WW'(lcg());
        W[j][i] = W[i][j];
      end
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) W[i][j] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check(!done, "R9 done", done, 0);
    check(cpl == '0 && ecc == '0, "R9 cpl/ecc", cpl, 0);
    check(radius == '0 && diameter == '0, "R9 radius/diameter", radius, 0);

    // R1 uniform full-scale weights: every distance is OFFS
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) W[i][j] = '1;
    run_check("R1 uniform", 1'b0);

    // R1 uniform mid weight
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) W[i][j] = WW'(100);
    run_check("R1 mid", 1'b0);

    // R2 random symmetric matrices
    for (int s = 1; s <= 4; s++) begin
      fill_random(s * 7919, 0);
      run_check("R2 random", 1'b0);
    end

    // R10 non-zero diagonal must not change results
    fill_random(3 * 7919, 200);
    run_check("R10 diagonal", 1'b0);

    // R2 chain: only neighbour links, multi-hop paths
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        W[i][j] = (j == i + 1 || i == j + 1) ? WW'(230) : '0;
    run_check("R2 chain", 1'b0);

    // R2 isolated last node: saturation
    fill_random(12345, 0);
    for (int i = 0; i < N; i++) begin
      W[i][N-1] = '0; W[N-1][i] = '0;
    end
    run_check("R2 saturate", 1'b0);

    // R1 weak links: large but unsaturated multi-hop sums
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) W[i][j] = WW'(1 + ((i + j) % 3));
    run_check("R1 weak", 1'b0);

    // R8 start pulses while busy
    fill_random(555, 0);
    run_check("R8 busy", 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule